// File: doc/BRIEF.md
# Processor Run-State Controller

This block follows the run-state of a processor core: normal execution, halted, low-power suspend, system-management mode (SMM) and shutdown. It takes decoded events from the core (a halt instruction has retired, a severe error was detected, SMM return), the three interrupt pins (SMI, NMI, INTR), the interrupt-enable flag, a configuration bit that turns a halt into a suspend, an active-low external suspend request, the warm and cold reset events, and two flags that report whether the descriptor table and the stack can take an NMI frame.

It answers with the current state, a one-clock stop-grant strobe on every entry into suspend, a bus-release level, the pending-interrupt latches and a one-clock dispatch request that names which interrupt to service. When a halt is left through an interrupt, the captured address of the instruction after the halt is presented as the return pointer. Interrupts that arrive while the controller may not act on them are held in the latches and dispatched one per cycle once the controller is back in normal execution.

Top module: `rs_runstate_ctl`

## Requirements
- R1: A low rst_n on a clock edge, or a cold_rst_i or warm_rst_i event in any state, puts the controller in RUN (state_o = 0) with all pending latches clear and no dispatch. These reset events take priority over every other input.
- R2: In RUN, a halt_retire_i with susp_on_halt_i = 0 moves to HALT (state_o = 1), bus_rel_o goes high, and ret_ptr_o takes the value on halt_npc_i.
- R3: In RUN, a halt_retire_i with susp_on_halt_i = 1 moves to SUSP (state_o = 2). stop_grant_o is high for exactly the first cycle of each stay in SUSP and never on later cycles of that stay.
- R4: HALT is left on SMI (to SMM, state_o = 3), on NMI, or on INTR while ie_flag_i = 1 (both to RUN), with a dispatch request. INTR while ie_flag_i = 0 has no effect.
- R5: Interrupts are ranked SMI, then NMI, then INTR (disp_kind_o = 0, 1, 2). Only one is dispatched per cycle. The others stay set in pend_o (bit 0 SMI, bit 1 NMI, bit 2 INTR) and are dispatched in later cycles.
- R6: In SMM, SMI, NMI and INTR (INTR only while ie_flag_i = 1) are latched and never dispatched. smm_rsm_i returns to RUN, and the latched interrupts are dispatched from the next cycle on.
- R7: In SMM, either a halt_retire_i or a low susp_req_n_i enters SUSP with a stop-grant strobe.
- R8: In a suspend entered through a low susp_req_n_i, all three interrupts are latched and none is dispatched. When susp_req_n_i returns high, the controller goes back to the state it came from, either RUN or SMM.
- R9: In a suspend entered by a halt from RUN, an SMI moves directly to SMM with an SMI dispatch. An NMI, or an INTR while ie_flag_i = 1, moves to RUN with a dispatch.
- R10: In a suspend entered by a halt from SMM, the first new interrupt is latched without a dispatch and returns the controller to SMM.
- R11: fatal_err_i in RUN or SMM enters SHUT (state_o = 4) and clears the latches. SHUT is left only by a reset event, or by an NMI while idt_ok_i and stk_ok_i are both 1, which goes to RUN with an NMI dispatch.
- R12: disp_vld_o and disp_kind_o appear in the first cycle after the one in which the interrupt that causes them is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cold_rst_i | input | 1 | Cold reset event |
| warm_rst_i | input | 1 | Warm reset event |
| halt_retire_i | input | 1 | A halt instruction has retired |
| halt_npc_i | input | AW | Address of the instruction after the halt |
| fatal_err_i | input | 1 | Severe error detected |
| smm_rsm_i | input | 1 | Return from SMM |
| smi_i | input | 1 | System-management interrupt |
| nmi_i | input | 1 | Non-maskable interrupt |
| intr_i | input | 1 | Maskable interrupt |
| ie_flag_i | input | 1 | Interrupt-enable flag |
| susp_on_halt_i | input | 1 | Turn a halt in RUN into a suspend |
| susp_req_n_i | input | 1 | External suspend request, active low |
| idt_ok_i | input | 1 | Descriptor table limit can hold the NMI vector |
| stk_ok_i | input | 1 | Stack has room for the NMI frame |
| state_o | output | 3 | 0 RUN, 1 HALT, 2 SUSP, 3 SMM, 4 SHUT |
| stop_grant_o | output | 1 | Stop-grant bus-cycle strobe |
| bus_rel_o | output | 1 | Local bus released (HALT or SUSP) |
| pend_o | output | 3 | Pending latches: bit 0 SMI, bit 1 NMI, bit 2 INTR |
| disp_vld_o | output | 1 | Dispatch request, one cycle |
| disp_kind_o | output | 2 | 0 SMI, 1 NMI, 2 INTR |
| ret_ptr_o | output | AW | Return pointer captured at the halt |

## Verification
The hardest cases to reach are the two kinds of suspend that sit inside SMM, because each needs an SMI to be dispatched first and then a second entry event. The stimulus goes to SMM with a live SMI and then uses the pin in one run and a halt in another. It injects interrupts in both suspends and checks that they stay in pend_o without a dispatch until after smm_rsm_i. A second hard case sends all three interrupts in a single cycle. The scoreboard then expects exactly the ordered sequence SMI, NMI, INTR, spread over the SMM round trip.

// File: rtl/rs_pkg.sv
// Shared types for the run-state controller.
// Assumes interrupt sources are indexed by priority, lowest index first.
package rs_pkg;
    localparam int NSRC    = 3;
    localparam int KW      = $clog2(NSRC);
    localparam int SRC_SMI = 0;
    localparam int SRC_NMI = 1;
    localparam int SRC_INT = 2;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_HALT = 3'd1,
        ST_SUSP = 3'd2,
        ST_SMM  = 3'd3,
        ST_SHUT = 3'd4
    } rs_state_e;
endpackage

// File: rtl/rs_prio_arb.sv
// Fixed-priority picker: grants the lowest-indexed active request.
// Assumes: purely combinational, N >= 2.
module rs_prio_arb #(
    parameter int N  = 3,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    logic [N-1:0] lower;

    // Mask of requests seen at a higher priority than each position.
    assign lower[0] = 1'b0;
    for (genvar g = 1; g < N; g++) begin : g_mask
        assign lower[g] = lower[g-1] | req_i[g-1];
    end

    // Grant goes to a request with nothing above it.
    for (genvar g = 0; g < N; g++) begin : g_gnt
        assign gnt_o[g] = req_i[g] & ~lower[g];
    end

    assign any_o = |req_i;

    // Binary index of the granted request.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_o[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/rs_pend_bank.sv
// Pending-interrupt latches: set by new arrivals, dropped on dispatch,
// cleared by reset events. Clear dominates, then drop, then set.
module rs_pend_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] drop_i,
    output logic [N-1:0] pend_o
);
    // Latch update per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) pend_o <= '0;
        else                 pend_o <= (pend_o | set_i) & ~drop_i;
    end

    // R1: a clear leaves nothing pending.
    assert_clear_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> pend_o == '0);

    // R5: without clear or drop, no latched interrupt is lost.
    assert_keep_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && drop_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/rs_runstate_ctl.sv
// Run-state controller: tracks RUN, HALT, SUSP, SMM and SHUT, latches
// interrupts that may not be acted on, and issues one dispatch per cycle.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module rs_runstate_ctl
    import rs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cold_rst_i,
    input  logic            warm_rst_i,
    input  logic            halt_retire_i,
    input  logic [AW-1:0]   halt_npc_i,
    input  logic            fatal_err_i,
    input  logic            smm_rsm_i,
    input  logic            smi_i,
    input  logic            nmi_i,
    input  logic            intr_i,
    input  logic            ie_flag_i,
    input  logic            susp_on_halt_i,
    input  logic            susp_req_n_i,
    input  logic            idt_ok_i,
    input  logic            stk_ok_i,
    output logic [2:0]      state_o,
    output logic            stop_grant_o,
    output logic            bus_rel_o,
    output logic [NSRC-1:0] pend_o,
    output logic            disp_vld_o,
    output logic [KW-1:0]   disp_kind_o,
    output logic [AW-1:0]   ret_ptr_o
);
    rs_state_e       state_q, state_n;
    logic            pin_q, pin_n;       // suspend entered through the pin
    logic            org_q, org_n;       // suspend entered from SMM
    logic            sg_q, sg_n;
    logic            dv_q, dv_n;
    logic [KW-1:0]   dk_q, dk_n;
    logic [AW-1:0]   ptr_q;
    logic            take_ptr;
    logic            rst_evt;
    logic [NSRC-1:0] live, req, gnt, set_v, drop_v;
    logic [KW-1:0]   gidx;
    logic            any_req, clr;

    assign rst_evt = cold_rst_i | warm_rst_i;

    // Interrupts seen this cycle, INTR masked by the enable flag.
    always_comb begin
        live          = '0;
        live[SRC_SMI] = smi_i;
        live[SRC_NMI] = nmi_i;
        live[SRC_INT] = intr_i & ie_flag_i;
    end

    assign req = pend_o | live;

    rs_prio_arb #(.N(NSRC), .IW(KW)) arb_i (
        .req_i (req),
        .gnt_o (gnt),
        .idx_o (gidx),
        .any_o (any_req)
    );

    rs_pend_bank #(.N(NSRC)) pend_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .set_i  (set_v),
        .drop_i (drop_v),
        .pend_o (pend_o)
    );

    // Next-state, latch control and dispatch decision.
    always_comb begin
        state_n  = state_q;
        pin_n    = pin_q;
        org_n    = org_q;
        sg_n     = 1'b0;
        dv_n     = 1'b0;
        dk_n     = dk_q;
        set_v    = '0;
        drop_v   = '0;
        clr      = 1'b0;
        take_ptr = 1'b0;
        if (rst_evt) begin
            state_n = ST_RUN;
            pin_n   = 1'b0;
            org_n   = 1'b0;
            clr     = 1'b1;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    set_v = live;
                    if (fatal_err_i) begin
                        state_n = ST_SHUT;
                        clr     = 1'b1;
                    end else if (any_req) begin
                        dv_n   = 1'b1;
                        dk_n   = gidx;
                        drop_v = gnt;
                        if (gnt[SRC_SMI]) state_n = ST_SMM;
                    end else if (halt_retire_i) begin
                        take_ptr = 1'b1;
                        if (susp_on_halt_i) begin
                            state_n = ST_SUSP;
                            pin_n   = 1'b0;
                            org_n   = 1'b0;
                            sg_n    = 1'b1;
                        end else begin
                            state_n = ST_HALT;
                        end
                    end else if (!susp_req_n_i) begin
                        state_n = ST_SUSP;
                        pin_n   = 1'b1;
                        org_n   = 1'b0;
                        sg_n    = 1'b1;
                    end
                end
                ST_HALT: begin
                    set_v = live;
                    if (any_req) begin
                        dv_n    = 1'b1;
                        dk_n    = gidx;
                        drop_v  = gnt;
                        state_n = gnt[SRC_SMI] ? ST_SMM : ST_RUN;
                    end
                end
                ST_SUSP: begin
                    set_v = live;
                    if (pin_q) begin
                        if (susp_req_n_i) state_n = org_q ? ST_SMM : ST_RUN;
                    end else if (org_q) begin
                        if (|live) state_n = ST_SMM;
                    end else if (any_req) begin
                        dv_n    = 1'b1;
                        dk_n    = gidx;
                        drop_v  = gnt;
                        state_n = gnt[SRC_SMI] ? ST_SMM : ST_RUN;
                    end
                end
                ST_SMM: begin
                    set_v = live;
                    if (fatal_err_i) begin
                        state_n = ST_SHUT;
                        clr     = 1'b1;
                    end else if (smm_rsm_i) begin
                        state_n = ST_RUN;
                    end else if (halt_retire_i || !susp_req_n_i) begin
                        state_n = ST_SUSP;
                        pin_n   = !halt_retire_i;
                        org_n   = 1'b1;
                        sg_n    = 1'b1;
                    end
                end
                ST_SHUT: begin
                    if (nmi_i && idt_ok_i && stk_ok_i) begin
                        state_n = ST_RUN;
                        dv_n    = 1'b1;
                        dk_n    = KW'(SRC_NMI);
                    end
                end
                default: state_n = ST_RUN;
            endcase
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pin_q   <= 1'b0;
            org_q   <= 1'b0;
            sg_q    <= 1'b0;
            dv_q    <= 1'b0;
            dk_q    <= '0;
        end else begin
            state_q <= state_n;
            pin_q   <= pin_n;
            org_q   <= org_n;
            sg_q    <= sg_n;
            dv_q    <= dv_n;
            dk_q    <= dk_n;
        end
    end

    // Return pointer captured when a halt retires in RUN.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (take_ptr) ptr_q <= halt_npc_i;
    end

    assign state_o      = state_q;
    assign stop_grant_o = sg_q;
    assign bus_rel_o    = (state_q == ST_HALT) || (state_q == ST_SUSP);
    assign disp_vld_o   = dv_q;
    assign disp_kind_o  = dk_q;
    assign ret_ptr_o    = ptr_q;

    // R1: reset events always land in RUN with nothing pending.
    assert_reset_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (state_q == ST_RUN) && (pend_o == '0) && !dv_q);

    // R3: the stop-grant strobe marks only the first cycle of a suspend.
    assert_sg_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sg_q |-> (state_q == ST_SUSP) && ($past(state_q) != ST_SUSP));

    // R5: at most one source is granted.
    assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R6: nothing is dispatched while in SMM.
    assert_smm_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SMM && !rst_evt) |=> !dv_q);

    // R8: pin suspend holds while the pin stays low.
    assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && pin_q && !susp_req_n_i && !rst_evt)
        |=> (state_q == ST_SUSP) && !dv_q);

    // R11: shutdown is kept without a qualified NMI or a reset.
    assert_shut_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHUT && !rst_evt && !(nmi_i && idt_ok_i && stk_ok_i))
        |=> state_q == ST_SHUT);
endmodule

// File: tb/rs_runstate_ctl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected dispatch kinds, a monitor
// pops them as dispatches appear; state and latch checks run in the driver.
module rs_runstate_ctl_tb_top;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cold_rst = 0, warm_rst = 0, halt_ret = 0, fatal = 0, rsm = 0;
    logic smi = 0, nmi = 0, intr = 0, ie = 1, soh = 0, susp_n = 1;
    logic idt_ok = 0, stk_ok = 0;
    logic [AW-1:0] npc = '0;
    logic [2:0]    state;
    logic          sg, brel, dvld;
    logic [2:0]    pend;
    logic [1:0]    dkind;
    logic [AW-1:0] rptr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    rs_runstate_ctl #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cold_rst_i(cold_rst), .warm_rst_i(warm_rst),
        .halt_retire_i(halt_ret), .halt_npc_i(npc), .fatal_err_i(fatal),
        .smm_rsm_i(rsm), .smi_i(smi), .nmi_i(nmi), .intr_i(intr),
        .ie_flag_i(ie), .susp_on_halt_i(soh), .susp_req_n_i(susp_n),
        .idt_ok_i(idt_ok), .stk_ok_i(stk_ok), .state_o(state),
        .stop_grant_o(sg), .bus_rel_o(brel), .pend_o(pend),
        .disp_vld_o(dvld), .disp_kind_o(dkind), .ret_ptr_o(rptr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        halt_ret = 0; fatal = 0; rsm = 0; smi = 0; nmi = 0; intr = 0;
        cold_rst = 0; warm_rst = 0;
    endtask

    task automatic expect_st(input int s, input string req);
        chk(state == 3'(s), req, state, s);
    endtask

    // Monitor: each dispatch must match the head of the expected queue (R12).
    always @(negedge clk) begin
        if (rst_n && dvld) begin
            if (exp_q.size() == 0) begin
                chk(0, "R12 unexpected dispatch", dkind, 3);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(dkind == 2'(e), "R5/R12 dispatch kind", dkind, e);
            end
        end
    end

    initial begin
        #(5.0 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        expect_st(0, "R1 reset state");
        chk(pend == 0 && !dvld && !sg, "R1 reset outputs", pend, 0);

        // R2 plain halt
        halt_ret = 1; npc = 32'h0000_1234; tick();
        expect_st(1, "R2 halt");
        chk(brel, "R2 bus release", brel, 1);
        chk(rptr == 32'h1234, "R2 return pointer", rptr, 32'h1234);

        // R4 masked INTR ignored, then enabled INTR exits
        ie = 0; intr = 1; tick(); ie = 1;
        expect_st(1, "R4 masked intr");
        chk(pend == 0, "R4 masked intr not latched", pend, 0);
        exp_q.push_back(2); intr = 1; tick();
        expect_st(0, "R4 intr exit");

        // R5 all three at once: SMI first, others latched through SMM (R6)
        exp_q.push_back(0); smi = 1; nmi = 1; intr = 1; tick();
        expect_st(3, "R5 smi wins");
        chk(pend == 3'b110, "R5 others latched", pend, 6);
        ie = 0; intr = 1; tick(); ie = 1;
        chk(pend == 3'b110, "R6 masked intr in SMM", pend, 6);
        rsm = 1; tick();
        expect_st(0, "R6 rsm to run");
        exp_q.push_back(1); tick();
        chk(pend == 3'b100, "R5 nmi dispatched", pend, 4);
        exp_q.push_back(2); tick();
        chk(pend == 3'b000, "R5 intr dispatched", pend, 0);

        // R7/R8 pin suspend inside SMM
        exp_q.push_back(0); smi = 1; tick();
        susp_n = 0; tick();
        expect_st(2, "R7 pin suspend from SMM");
        chk(sg, "R3 strobe on entry", sg, 1);
        tick();
        chk(!sg, "R3 no strobe while suspended", sg, 0);
        nmi = 1; tick();
        chk(pend == 3'b010, "R8 nmi latched", pend, 2);
        susp_n = 1; tick();
        expect_st(3, "R8 back to SMM");
        rsm = 1; tick();
        exp_q.push_back(1); tick();
        expect_st(0, "R6 run after nmi");

        // R10 halt suspend inside SMM
        exp_q.push_back(0); smi = 1; tick();
        halt_ret = 1; tick();
        expect_st(2, "R7 halt suspend from SMM");
        chk(sg, "R3 strobe halt entry", sg, 1);
        tick();
        expect_st(2, "R10 idle stays");
        intr = 1; tick();
        expect_st(3, "R10 wake to SMM");
        chk(pend == 3'b100, "R10 intr latched", pend, 4);
        rsm = 1; tick();
        exp_q.push_back(2); tick();

        // R9 halt suspend from RUN
        soh = 1; halt_ret = 1; tick();
        expect_st(2, "R3 halt to suspend");
        chk(sg && brel, "R3 strobe", sg, 1);
        tick();
        exp_q.push_back(0); smi = 1; tick();
        expect_st(3, "R9 smi to SMM");
        rsm = 1; tick();
        halt_ret = 1; tick();
        exp_q.push_back(1); nmi = 1; tick();
        expect_st(0, "R9 nmi to run");
        soh = 0;

        // R8 pin suspend from RUN
        susp_n = 0; tick();
        expect_st(2, "R8 pin suspend from run");
        intr = 1; tick();
        chk(pend == 3'b100 && !dvld, "R8 intr held", pend, 4);
        susp_n = 1; tick();
        expect_st(0, "R8 back to run");
        exp_q.push_back(2); tick();

        // R11 shutdown
        fatal = 1; tick();
        expect_st(4, "R11 enter shutdown");
        idt_ok = 1; stk_ok = 0; nmi = 1; tick();
        expect_st(4, "R11 nmi refused");
        stk_ok = 1; exp_q.push_back(1); nmi = 1; tick();
        expect_st(0, "R11 nmi exit");

        // R1 warm reset beats a qualified NMI in shutdown
        fatal = 1; tick();
        warm_rst = 1; nmi = 1; tick();
        expect_st(0, "R1 warm reset");
        tick();
        // R1 cold reset from SMM clears latches
        exp_q.push_back(0); smi = 1; tick();
        intr = 1; tick();
        chk(pend == 3'b100, "R6 intr latched", pend, 4);
        cold_rst = 1; tick();
        expect_st(0, "R1 cold reset");
        chk(pend == 0, "R1 latches cleared", pend, 0);
        tick(); tick();
        chk(exp_q.size() == 0, "R12 all dispatches seen", exp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule